// File: doc/BRIEF.md
# Answer-to-Reset Decoder

After a card reset, the card sends a variable-length answer whose first bytes describe how the rest of the session must be run. This block sits behind the character receiver and takes that answer one byte at a time. The receiver has already framed each byte and, for the inverse convention, already undone the level inversion. The decoder reads the convention byte and then walks the presence nibbles of the format byte and of each protocol-chaining byte, so it always knows which interface byte comes next. It then counts off the historical bytes and, when a protocol other than type 0 has been announced, checks the closing check byte.

Once the answer is complete the block holds its results until the next `start` pulse. The results are the convention, the raw clock and baud codes, the clock conversion factor F, the baud divisor D (given as a signed power of two), the resulting elementary time unit in clock cycles, the extra guard time, the first announced protocol, the negotiable/specific mode flag and the historical byte count. An illegal first byte, a bad check byte or a reserved clock/baud code each raise a flag of their own.

Top module: `atr_decoder`

## Requirements
- R1: The first byte after `start` sets the convention: 3Bh gives `conv_inv`=0, 3Fh gives `conv_inv`=1. Any other value sets `err_ts` and `done` in the next cycle, and no later byte is decoded.
- R2: In the format byte (the second byte), bits 4, 5, 6 and 7 announce the first-level interface bytes A, B, C and D, which arrive in that order. Bits 3:0 give the number of historical bytes, and `hist_count` ends equal to that number.
- R3: Bits 7:4 of every D-type interface byte announce the A, B, C and D bytes of the next level, using the same bit order. Bits 3:0 of the first D byte appear on `protocol`, which is 0 when no D byte is present.
- R4: The first-level A byte supplies `fi_code` (bits 7:4) and `di_code` (bits 3:0). Both codes are 1 when that byte is absent. `f_factor` maps codes 1..6 to 372, 558, 744, 1116, 1488 and 1860, and codes 9..13 to 512, 768, 1024, 1536 and 2048.
- R5: `d_exp` is the base-2 exponent of D, in 4-bit two's complement. Di codes 1..5 give D = 1, 2, 4, 8 and 16, and codes 10..15 give D = 1/2 down to 1/64. `etu` equals floor(F/D).
- R6: A reserved Fi code (0, 7, 8, 14, 15) or a reserved Di code (0, 6..9) sets `unsupported`. In that case the block gives F=372, `d_exp`=0 and `etu`=372.
- R7: The first-level C byte appears on `extra_guard`, which is 0 when that byte is absent.
- R8: Bit 7 of the second-level A byte appears on `specific_mode`, which is 0 when that byte is absent.
- R9: A check byte is expected, and `tck_present` is set, when any D byte has a nonzero value in bits 3:0. The XOR of all bytes from the format byte through the check byte must be zero; otherwise `err_tck` is set.
- R10: `done` rises in the cycle after the last byte of the answer and stays high until `start`. `start` returns every output to its reset value. Bytes that arrive before the first `start`, or after `done`, change no output.
- R11: After reset, `done`, all error flags, `conv_inv`, `extra_guard`, `protocol`, `specific_mode`, `hist_count` and `tck_present` are 0, and the block gives F=372, `d_exp`=0 and `etu`=372.
- R12: The answer 3B 3B 94 00 followed by eleven historical bytes decodes to F=512, D=8 (`d_exp`=3), `etu`=64, `hist_count`=11, with no check byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears the results and arms decoding of a new answer |
| byte_valid | input | 1 | Qualifies `byte_data` for one cycle |
| byte_data | input | 8 | Received byte, already in logical polarity |
| done | output | 1 | The answer is complete and the results are valid |
| err_ts | output | 1 | The first byte was neither 3Bh nor 3Fh |
| err_tck | output | 1 | The check byte did not make the XOR zero |
| unsupported | output | 1 | Reserved Fi or Di code; the defaults are in use |
| conv_inv | output | 1 | Inverse convention |
| fi_code | output | 4 | Raw clock conversion code |
| di_code | output | 4 | Raw baud adjustment code |
| f_factor | output | 12 | Clock conversion factor F |
| d_exp | output | 4 | log2(D), two's complement |
| etu | output | 18 | Clock cycles per elementary time unit |
| extra_guard | output | 8 | Extra guard time in ETUs |
| protocol | output | 4 | First announced protocol type |
| specific_mode | output | 1 | Specific mode (no negotiation) |
| hist_count | output | 4 | Historical bytes received |
| tck_present | output | 1 | A check byte is expected |

## Verification
The bound checker watches on every cycle that the results stay frozen while `done` is held, that `start` clears the completion and error flags, that an error flag never appears without `done`, and that a reserved code always yields the default F, D and ETU. Several things can only be shown by the bench's scenarios, because each depends on the full byte sequence: whether the presence masks are followed correctly through chained levels, whether F, D and ETU are decoded correctly for each code, whether the check byte is required only for nonzero protocols, and whether the XOR test catches corruption. The bench builds random answers together with their expected fields, and adds directed cases for the worked example, the two conventions, a bad first byte, reserved codes and bytes arriving while the block is idle.

// File: rtl/atr_decoder.sv
module atr_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        byte_valid,
  input  logic [7:0]  byte_data,
  output logic        done,
  output logic        err_ts,
  output logic        err_tck,
  output logic        unsupported,
  output logic        conv_inv,
  output logic [3:0]  fi_code,
  output logic [3:0]  di_code,
  output logic [11:0] f_factor,
  output logic [3:0]  d_exp,
  output logic [17:0] etu,
  output logic [7:0]  extra_guard,
  output logic [3:0]  protocol,
  output logic        specific_mode,
  output logic [3:0]  hist_count,
  output logic        tck_present
);

  typedef enum logic [2:0] {S_IDLE, S_TS, S_T0, S_IF, S_HIST, S_TCK, S_DONE} st_t;

  st_t        st;
  logic [3:0] mask, hist_left;
  logic [1:0] lvl;
  logic [7:0] ta1, xacc;

  logic [1:0] sel;
  logic [3:0] mask_nx;
  logic       tck_nx;
  wire  [7:0] xb = xacc ^ byte_data;

  always_comb begin
    if (mask[0])      sel = 2'd0;
    else if (mask[1]) sel = 2'd1;
    else if (mask[2]) sel = 2'd2;
    else              sel = 2'd3;
  end

  assign mask_nx = (sel == 2'd3) ? byte_data[7:4] : (mask & ~(4'b0001 << sel));
  assign tck_nx  = tck_present | ((sel == 2'd3) && (byte_data[3:0] != 4'd0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; mask <= '0; hist_left <= '0; lvl <= '0;
      ta1 <= 8'h11; xacc <= '0;
      err_ts <= 1'b0; err_tck <= 1'b0; conv_inv <= 1'b0;
      extra_guard <= '0; protocol <= '0; specific_mode <= 1'b0;
      hist_count <= '0; tck_present <= 1'b0;
    end else if (start) begin
      st <= S_TS; mask <= '0; hist_left <= '0; lvl <= '0;
      ta1 <= 8'h11; xacc <= '0;
      err_ts <= 1'b0; err_tck <= 1'b0; conv_inv <= 1'b0;
      extra_guard <= '0; protocol <= '0; specific_mode <= 1'b0;
      hist_count <= '0; tck_present <= 1'b0;
    end else if (byte_valid) begin
      case (st)
        S_TS: begin
          if (byte_data == 8'h3B) begin
            conv_inv <= 1'b0; st <= S_T0;
          end else if (byte_data == 8'h3F) begin
            conv_inv <= 1'b1; st <= S_T0;
          end else begin
            err_ts <= 1'b1; st <= S_DONE;
          end
        end
        S_T0: begin
          xacc      <= byte_data;
          mask      <= byte_data[7:4];
          hist_left <= byte_data[3:0];
          if (byte_data[7:4] != 4'd0)      st <= S_IF;
          else if (byte_data[3:0] != 4'd0) st <= S_HIST;
          else                             st <= S_DONE;
        end
        S_IF: begin
          xacc <= xb;
          case (sel)
            2'd0: begin
              if (lvl == 2'd0) ta1 <= byte_data;
              if (lvl == 2'd1) specific_mode <= byte_data[7];
            end
            2'd2: if (lvl == 2'd0) extra_guard <= byte_data;
            2'd3: begin
              if (lvl == 2'd0) protocol <= byte_data[3:0];
              if (lvl != 2'd3) lvl <= lvl + 2'd1;
            end
            default: ;
          endcase
          mask        <= mask_nx;
          tck_present <= tck_nx;
          if (mask_nx == 4'd0) begin
            if (hist_left != 4'd0) st <= S_HIST;
            else if (tck_nx)       st <= S_TCK;
            else                   st <= S_DONE;
          end
        end
        S_HIST: begin
          xacc       <= xb;
          hist_count <= hist_count + 4'd1;
          hist_left  <= hist_left - 4'd1;
          if (hist_left == 4'd1) st <= tck_present ? S_TCK : S_DONE;
        end
        S_TCK: begin
          err_tck <= (xb != 8'd0);
          st      <= S_DONE;
        end
        default: ;
      endcase
    end
  end

  assign done    = (st == S_DONE);
  assign fi_code = ta1[7:4];
  assign di_code = ta1[3:0];

  logic [11:0] f_raw;
  logic [3:0]  d_raw;
  logic        fi_ok, di_ok;

  always_comb begin
    fi_ok = 1'b1;
    case (fi_code)
      4'd1:    f_raw = 12'd372;
      4'd2:    f_raw = 12'd558;
      4'd3:    f_raw = 12'd744;
      4'd4:    f_raw = 12'd1116;
      4'd5:    f_raw = 12'd1488;
      4'd6:    f_raw = 12'd1860;
      4'd9:    f_raw = 12'd512;
      4'd10:   f_raw = 12'd768;
      4'd11:   f_raw = 12'd1024;
      4'd12:   f_raw = 12'd1536;
      4'd13:   f_raw = 12'd2048;
      default: begin f_raw = 12'd372; fi_ok = 1'b0; end
    endcase
  end

  always_comb begin
    di_ok = 1'b1;
    if (di_code >= 4'd1 && di_code <= 4'd5)
      d_raw = di_code - 4'd1;
    else if (di_code >= 4'd10)
      d_raw = 4'd9 - di_code;
    else begin
      d_raw = 4'd0; di_ok = 1'b0;
    end
  end

  assign unsupported = !(fi_ok && di_ok);
  assign f_factor    = unsupported ? 12'd372 : f_raw;
  assign d_exp       = unsupported ? 4'd0 : d_raw;

  wire [3:0] d_mag = d_exp[3] ? (4'd0 - d_exp) : d_exp;
  assign etu = d_exp[3] ? ({6'd0, f_factor} << d_mag) : {6'd0, f_factor >> d_mag};

endmodule

// File: rtl/atr_decoder_chk.sv
module atr_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        done,
  input logic        err_ts,
  input logic        err_tck,
  input logic        unsupported,
  input logic [11:0] f_factor,
  input logic [3:0]  d_exp,
  input logic [17:0] etu,
  input logic [7:0]  extra_guard,
  input logic [3:0]  protocol,
  input logic [3:0]  hist_count,
  input logic        tck_present
);

  p_done_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  p_frozen_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> $stable(f_factor) && $stable(protocol) && $stable(hist_count)
                       && $stable(extra_guard) && $stable(err_tck) && $stable(err_ts));

  p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done && !err_ts && !err_tck && hist_count == 4'd0 && !tck_present);

  p_bad_ts_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    err_ts |-> done);

  p_tck_err_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_tck |-> done && tck_present);

  p_unsup_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported |-> f_factor == 12'd372 && d_exp == 4'd0 && etu == 18'd372);

endmodule

bind atr_decoder atr_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .err_ts(err_ts),
  .err_tck(err_tck), .unsupported(unsupported), .f_factor(f_factor), .d_exp(d_exp),
  .etu(etu), .extra_guard(extra_guard), .protocol(protocol), .hist_count(hist_count),
  .tck_present(tck_present)
);

// File: tb/atr_decoder_tb.sv
module atr_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic done, err_ts, err_tck, unsupported, conv_inv, specific_mode, tck_present;
  logic [3:0] fi_code, di_code, d_exp, protocol, hist_count;
  logic [11:0] f_factor;
  logic [17:0] etu;
  logic [7:0] extra_guard;

  atr_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_valid(byte_valid), .byte_data(byte_data),
    .done(done), .err_ts(err_ts), .err_tck(err_tck), .unsupported(unsupported),
    .conv_inv(conv_inv), .fi_code(fi_code), .di_code(di_code), .f_factor(f_factor),
    .d_exp(d_exp), .etu(etu), .extra_guard(extra_guard), .protocol(protocol),
    .specific_mode(specific_mode), .hist_count(hist_count), .tck_present(tck_present)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] atr [0:63];
  int alen;
  bit e_inv, e_bad_ts, e_spec, e_tck, e_bad_tck;
  logic [7:0] e_ta1, e_tc1;
  int e_proto, e_k;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int f_tab(input int c);
    case (c)
      1: return 372;  2: return 558;  3: return 744;  4: return 1116;
      5: return 1488; 6: return 1860; 9: return 512;  10: return 768;
      11: return 1024; 12: return 1536; 13: return 2048;
      default: return 0;
    endcase
  endfunction

  function automatic void d_tab(input int c, output int num, output int den);
    num = 0; den = 1;
    case (c)
      1: num = 1;  2: num = 2;  3: num = 4;  4: num = 8;  5: num = 16;
      10: begin num = 1; den = 2;  end
      11: begin num = 1; den = 4;  end
      12: begin num = 1; den = 8;  end
      13: begin num = 1; den = 16; end
      14: begin num = 1; den = 32; end
      15: begin num = 1; den = 64; end
      default: num = 0;
    endcase
  endfunction

  function automatic int lg2(input int v);
    int r = 0;
    while ((1 << r) < v) r++;
    return r;
  endfunction

  task automatic clear_exp();
    alen = 0; e_inv = 0; e_bad_ts = 0; e_spec = 0; e_tck = 0; e_bad_tck = 0;
    e_ta1 = 8'h11; e_tc1 = 8'h00; e_proto = 0; e_k = 0;
  endtask

  task automatic push(input logic [7:0] b);
    atr[alen] = b; alen++;
  endtask

  task automatic send(input logic [7:0] b, input bit gaps);
    if (gaps) repeat ($urandom % 3) @(negedge clk);
    @(negedge clk); byte_valid = 1'b1; byte_data = b;
    @(negedge clk); byte_valid = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic compare_all(string ctx);
    int f, num, den, fo, dx, eo;
    bit uns;
    f = f_tab(int'(e_ta1[7:4]));
    d_tab(int'(e_ta1[3:0]), num, den);
    uns = (f == 0) || (num == 0);
    if (uns) begin fo = 372; dx = 0; eo = 372; end
    else begin
      fo = f;
      dx = (num >= 1 && den == 1) ? lg2(num) : -lg2(den);
      eo = (f * den) / num;
    end
    chk("R10", {ctx, " done"}, int'(done), 1);
    chk("R1", {ctx, " err_ts"}, int'(err_ts), int'(e_bad_ts));
    chk("R1", {ctx, " conv_inv"}, int'(conv_inv), e_bad_ts ? 0 : int'(e_inv));
    chk("R4", {ctx, " fi_code"}, int'(fi_code), int'(e_ta1[7:4]));
    chk("R4", {ctx, " di_code"}, int'(di_code), int'(e_ta1[3:0]));
    chk("R4", {ctx, " f_factor"}, int'(f_factor), fo);
    chk("R5", {ctx, " d_exp"}, int'($signed(d_exp)), dx);
    chk("R5", {ctx, " etu"}, int'(etu), eo);
    chk("R6", {ctx, " unsupported"}, int'(unsupported), int'(uns));
    chk("R7", {ctx, " extra_guard"}, int'(extra_guard), int'(e_tc1));
    chk("R3", {ctx, " protocol"}, int'(protocol), e_proto);
    chk("R8", {ctx, " specific_mode"}, int'(specific_mode), int'(e_spec));
    chk("R2", {ctx, " hist_count"}, int'(hist_count), e_k);
    chk("R9", {ctx, " tck_present"}, int'(tck_present), int'(e_tck));
    chk("R9", {ctx, " err_tck"}, int'(err_tck), int'(e_bad_tck));
  endtask

  task automatic run_atr(string ctx, bit gaps);
    pulse_start();
    chk("R10", {ctx, " cleared by start"}, int'(done), 0);
    for (int i = 0; i < alen; i++) send(atr[i], gaps);
    compare_all(ctx);
  endtask

  task automatic gen_random();
    logic [3:0] cur, nxt;
    logic [7:0] v, x;
    int ntd;
    clear_exp();
    e_inv = 1'($urandom % 2);
    push(e_inv ? 8'h3F : 8'h3B);
    ntd = $urandom % 4;
    e_k = $urandom % 16;
    cur = {ntd >= 1, 3'($urandom % 8)};
    push({cur, 4'(e_k)});
    for (int lev = 1; lev <= 4; lev++) begin
      if (cur[0]) begin
        v = 8'($urandom);
        if (lev == 1 && ($urandom % 2) == 1) begin
          case ($urandom % 11)
            0: v[7:4] = 1; 1: v[7:4] = 2; 2: v[7:4] = 3; 3: v[7:4] = 4;
            4: v[7:4] = 5; 5: v[7:4] = 6; 6: v[7:4] = 9; 7: v[7:4] = 10;
            8: v[7:4] = 11; 9: v[7:4] = 12; default: v[7:4] = 13;
          endcase
          v[3:0] = (($urandom % 2) == 1) ? 4'(1 + $urandom % 5) : 4'(10 + $urandom % 6);
        end
        if (lev == 1) e_ta1 = v;
        if (lev == 2) e_spec = v[7];
        push(v);
      end
      if (cur[1]) push(8'($urandom));
      if (cur[2]) begin
        v = 8'($urandom);
        if (lev == 1) e_tc1 = v;
        push(v);
      end
      if (!cur[3]) break;
      v[3:0] = (($urandom % 3) == 0) ? 4'($urandom) : 4'($urandom % 2);
      nxt = {lev < ntd, 3'($urandom % 8)};
      if (lev == 1) e_proto = int'(v[3:0]);
      if (v[3:0] != 0) e_tck = 1;
      push({nxt, v[3:0]});
      cur = nxt;
    end
    for (int i = 0; i < e_k; i++) push(8'($urandom));
    if (e_tck) begin
      x = 8'h00;
      for (int i = 1; i < alen; i++) x ^= atr[i];
      if (($urandom % 4) == 0) begin x ^= 8'(1 << ($urandom % 8)); e_bad_tck = 1; end
      push(x);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7816));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11", "done", int'(done), 0);
    chk("R11", "err flags", int'(err_ts | err_tck | unsupported), 0);
    chk("R11", "f_factor", int'(f_factor), 372);
    chk("R11", "etu", int'(etu), 372);
    chk("R11", "hist_count", int'(hist_count), 0);
    chk("R11", "conv_inv", int'(conv_inv), 0);

    // R10 bytes before any start are ignored
    send(8'h3F, 0); send(8'h00, 0);
    chk("R10", "idle done", int'(done), 0);
    chk("R10", "idle conv_inv", int'(conv_inv), 0);

    // R12 worked example
    clear_exp();
    push(8'h3B); push(8'h3B); push(8'h94); push(8'h00);
    for (int i = 0; i < 11; i++) push(8'(8'h20 + i));
    e_ta1 = 8'h94; e_k = 11;
    run_atr("R12 example", 0);
    chk("R12", "etu", int'(etu), 64);
    chk("R12", "d_exp", int'($signed(d_exp)), 3);
    // R10 byte after done is ignored
    send(8'h55, 0);
    chk("R10", "post-done hist_count", int'(hist_count), 11);
    chk("R10", "post-done f_factor", int'(f_factor), 512);
    chk("R10", "post-done done", int'(done), 1);

    // R1 inverse convention, minimal answer
    clear_exp(); push(8'h3F); push(8'h00); e_inv = 1;
    run_atr("R1 inverse", 0);

    // R1 illegal first byte
    clear_exp(); push(8'h12); push(8'h00); push(8'h31); e_bad_ts = 1;
    run_atr("R1 bad ts", 0);

    // R6 reserved Fi, then reserved Di
    clear_exp(); push(8'h3B); push(8'h10); push(8'h74); e_ta1 = 8'h74;
    run_atr("R6 reserved fi", 0);
    chk("R6", "unsupported fi", int'(unsupported), 1);
    clear_exp(); push(8'h3B); push(8'h10); push(8'h16); e_ta1 = 8'h16;
    run_atr("R6 reserved di", 0);
    chk("R6", "unsupported di", int'(unsupported), 1);

    // R9 protocol 1 with good and corrupted check byte
    clear_exp(); push(8'h3B); push(8'h80); push(8'h01); push(8'h81);
    e_proto = 1; e_tck = 1;
    run_atr("R9 good tck", 0);
    clear_exp(); push(8'h3B); push(8'h80); push(8'h01); push(8'h82);
    e_proto = 1; e_tck = 1; e_bad_tck = 1;
    run_atr("R9 bad tck", 0);

    // R8 second-level A byte selects specific mode; R3 chaining
    clear_exp(); push(8'h3B); push(8'h90); push(8'h11); push(8'h10); push(8'h80);
    e_spec = 1;
    run_atr("R8 specific", 0);
    chk("R8", "specific_mode", int'(specific_mode), 1);

    // R10 restart in the middle of an answer
    pulse_start(); send(8'h3B, 0); send(8'hF3, 0);
    clear_exp(); push(8'h3B); push(8'h40); push(8'h07); e_tc1 = 8'h07;
    run_atr("R10 restart R7", 0);

    for (int n = 0; n < 80; n++) begin
      gen_random();
      run_atr("random", 1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule